// File: doc/BRIEF.md
# Multi-Channel DMA Transfer Sequencer

This block keeps the control state of a small set of DMA channels (two by default) and decides, one cycle at a time, whether a channel may move a single transfer unit. Software programs each channel through a register-style port: source address, destination address, unit count and a control byte. A separate global register holds the master enable and two sticky fault flags, one for a non-maskable interrupt and one for an address error. Each granted unit is issued as one single-beat request on a simple bus-master handshake. The request is held until the bus acknowledges it or until the channel loses its permission to run.

Only dual-address, cycle-steal transfers are handled. After every unit the sequencer returns to idle for at least one cycle and arbitrates again. The source and destination addresses step forward by the unit size when their increment bits are set. The count drops by one per acknowledged unit. When the count reaches zero, the channel's end flag is set, and the channel's interrupt line follows that flag when interrupts are enabled.

Top module: `dma_seq`

## Requirements
- R1: A channel is eligible only when all of the following hold: its enable (control bit 0) is 1, its end flag (control bit 1) is 0, the global master enable (global bit 0) is 1, the NMI flag (global bit 1) is 0 and the address-error flag (global bit 2) is 0. A channel with a zero count is never eligible.
- R2: Clearing the master enable while a unit is pending drops `bus_req_o` in the next cycle on every channel without changing the count, and transfers resume once it is set again. Clearing a channel's own enable drops that channel's pending unit in the same way.
- R3: With auto-request (control bit 3) set, an enabled channel requests units without any `req_i`. With auto-request clear, the channel issues a unit only while its `req_i` bit is 1.
- R4: Each grant moves one unit. Size field control[5:4] selects the unit: 0 = byte, 1 = halfword, 2 = word, 3 = word. `bus_size_o` reports the effective size (0, 1 or 2). The source address advances by the unit size in bytes when control bit 6 is set, the destination when control bit 7 is set, and otherwise stays fixed.
- R5: Every acknowledged unit (`bus_req_o` and `bus_ack_i` high at a clock edge) decrements the channel count by 1.
- R6: When the count goes from 1 to 0, the channel's end flag is set and no further units are issued. `irq_o[i]` equals end flag AND interrupt enable (control bit 2).
- R7: If the granted channel's source or destination address is not a multiple of its unit size, the address-error flag is set and no bus request is issued. While that flag is set, no channel transfers.
- R8: A high `nmi_i` sets the NMI flag at the next edge, so `bus_req_o` is low in the following cycle. No channel transfers until software clears the flag.
- R9: When several channels are eligible, the lowest-numbered channel is granted first.
- R10: After reset, every register reads 0, `bus_req_o` is low and every `irq_o` bit is low.
- R11: The end, NMI and address-error flags are sticky. Writing 1 to them leaves them unchanged and writing 0 clears them. A channel whose end flag is 1 stays idle even after its count is reloaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Channel register write strobe |
| cfg_ch_i | input | CHW | Channel select for write and read |
| cfg_sel_i | input | 2 | Register select: 0 source, 1 destination, 2 count, 3 control |
| cfg_wdata_i | input | AW | Channel register write data |
| cfg_rdata_o | output | AW | Selected channel register, zero-extended |
| glb_we_i | input | 1 | Global register write strobe |
| glb_wdata_i | input | 3 | Global write data: bit0 enable, bit1 NMI flag, bit2 address-error flag |
| glb_rdata_o | output | 3 | Global register contents |
| nmi_i | input | 1 | Non-maskable interrupt event |
| req_i | input | N_CH | Per-channel transfer requests |
| bus_req_o | output | 1 | Single-beat bus request |
| bus_src_o | output | AW | Source address of the pending unit |
| bus_dst_o | output | AW | Destination address of the pending unit |
| bus_size_o | output | 2 | Effective unit size of the pending unit |
| bus_ch_o | output | CHW | Channel owning the pending unit |
| bus_ack_i | input | 1 | Bus acknowledge, completes the unit |
| irq_o | output | N_CH | Per-channel end-of-transfer interrupts |

## Verification
The bench drops the master enable and then a channel enable while a unit is still waiting for acknowledge. A design that let the request stand would complete a unit it was told to abandon and lower the count. It reloads the count of a channel whose end flag is still set, and it writes 1 to that flag; a design that restarted there, or that let the write clear the flag, would issue an extra unit. A halfword unit at an odd source address must raise the address error and freeze the other channel too, so a design that checked alignment late would put a bad access on the bus. With both channels requesting, a reversed priority would show as channel 1 appearing on `bus_ch_o` first.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

  localparam logic [1:0] SEL_SRC  = 2'd0;
  localparam logic [1:0] SEL_DST  = 2'd1;
  localparam logic [1:0] SEL_CNT  = 2'd2;
  localparam logic [1:0] SEL_CTRL = 2'd3;

  typedef struct packed {
    logic       dst_inc;
    logic       src_inc;
    logic [1:0] size;
    logic       auto_req;
    logic       irq_en;
    logic       done;
    logic       en;
  } ctrl_t;

  function automatic logic [1:0] eff_size(input logic [1:0] sz);
    return (sz == 2'd3) ? 2'd2 : sz;
  endfunction

  function automatic logic [2:0] unit_bytes(input logic [1:0] sz);
    case (sz)
      2'd0:    return 3'd1;
      2'd1:    return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

  function automatic logic addr_ok(input logic [1:0] lo, input logic [1:0] sz);
    case (sz)
      2'd0:    return 1'b1;
      2'd1:    return ~lo[0];
      default: return lo == 2'b00;
    endcase
  endfunction

endpackage

// File: rtl/dma_seq_chan.sv
module dma_seq_chan
  import dma_seq_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [1:0]    sel_i,
  input  logic [AW-1:0] wdata_i,
  input  logic          step_i,
  output logic [AW-1:0] src_o,
  output logic [AW-1:0] dst_o,
  output logic [CW-1:0] cnt_o,
  output ctrl_t         ctrl_o
);

  ctrl_t         ctrl_wr;
  logic [AW-1:0] stride;

  always_comb begin
    ctrl_wr      = ctrl_t'(wdata_i[7:0]);
    ctrl_wr.done = ctrl_o.done & wdata_i[1]; // sticky: only a 0 clears
    stride       = AW'(unit_bytes(ctrl_o.size));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_o  <= '0;
      dst_o  <= '0;
      cnt_o  <= '0;
      ctrl_o <= '0;
    end else if (wr_i) begin
      case (sel_i)
        SEL_SRC:  src_o  <= wdata_i;
        SEL_DST:  dst_o  <= wdata_i;
        SEL_CNT:  cnt_o  <= wdata_i[CW-1:0];
        default:  ctrl_o <= ctrl_wr;
      endcase
    end else if (step_i) begin
      cnt_o <= cnt_o - 1'b1;
      if (ctrl_o.src_inc) src_o <= src_o + stride;
      if (ctrl_o.dst_inc) dst_o <= dst_o + stride;
      if (cnt_o == CW'(1)) ctrl_o.done <= 1'b1;
    end
  end

endmodule

// File: rtl/dma_seq_arb.sv
module dma_seq_arb #(
  parameter int N   = 2,
  parameter int IW  = 1
) (
  input  logic [N-1:0]  req_i,
  output logic [N-1:0]  gnt_o,
  output logic [IW-1:0] idx_o,
  output logic          any_o
);

  always_comb begin
    gnt_o = '0;
    idx_o = '0;
    any_o = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        gnt_o = '0;
        gnt_o[i] = 1'b1;
        idx_o = IW'(i);
        any_o = 1'b1;
      end
    end
  end

endmodule

// File: rtl/dma_seq.sv
module dma_seq
  import dma_seq_pkg::*;
#(
  parameter int N_CH = 2,
  parameter int AW   = 32,
  parameter int CW   = 16,
  localparam int CHW = (N_CH > 1) ? $clog2(N_CH) : 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            cfg_we_i,
  input  logic [CHW-1:0]  cfg_ch_i,
  input  logic [1:0]      cfg_sel_i,
  input  logic [AW-1:0]   cfg_wdata_i,
  output logic [AW-1:0]   cfg_rdata_o,
  input  logic            glb_we_i,
  input  logic [2:0]      glb_wdata_i,
  output logic [2:0]      glb_rdata_o,
  input  logic            nmi_i,
  input  logic [N_CH-1:0] req_i,
  output logic            bus_req_o,
  output logic [AW-1:0]   bus_src_o,
  output logic [AW-1:0]   bus_dst_o,
  output logic [1:0]      bus_size_o,
  output logic [CHW-1:0]  bus_ch_o,
  input  logic            bus_ack_i,
  output logic [N_CH-1:0] irq_o
);

  logic [AW-1:0]  src_a  [N_CH];
  logic [AW-1:0]  dst_a  [N_CH];
  logic [CW-1:0]  cnt_a  [N_CH];
  ctrl_t          ctrl_a [N_CH];
  logic [N_CH-1:0] elig, step, gnt;
  logic [CHW-1:0] gnt_idx, cur_ch_q;
  logic           gnt_any, busy_q, me_q, nmi_q, ae_q;
  logic           run_ok, abort_c, align_ok, misalign_c;
  ctrl_t          cur_ctrl;
  logic [CW-1:0]  cur_cnt;

  assign run_ok = me_q & ~nmi_q & ~ae_q;

  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    dma_seq_chan #(.AW(AW), .CW(CW)) u_chan (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .wr_i    (cfg_we_i && (cfg_ch_i == CHW'(g))),
      .sel_i   (cfg_sel_i),
      .wdata_i (cfg_wdata_i),
      .step_i  (step[g]),
      .src_o   (src_a[g]),
      .dst_o   (dst_a[g]),
      .cnt_o   (cnt_a[g]),
      .ctrl_o  (ctrl_a[g])
    );
    assign elig[g]  = run_ok & ctrl_a[g].en & ~ctrl_a[g].done & (cnt_a[g] != '0)
                    & (ctrl_a[g].auto_req | req_i[g]);
    assign step[g]  = bus_req_o & bus_ack_i & (cur_ch_q == CHW'(g));
    assign irq_o[g] = ctrl_a[g].done & ctrl_a[g].irq_en;
  end

  dma_seq_arb #(.N(N_CH), .IW(CHW)) u_arb (
    .req_i (elig),
    .gnt_o (gnt),
    .idx_o (gnt_idx),
    .any_o (gnt_any)
  );

  // alignment is judged before the unit reaches the bus
  assign align_ok   = addr_ok(src_a[gnt_idx][1:0], ctrl_a[gnt_idx].size)
                    & addr_ok(dst_a[gnt_idx][1:0], ctrl_a[gnt_idx].size);
  assign misalign_c = ~busy_q & gnt_any & ~align_ok;

  assign cur_ctrl = ctrl_a[cur_ch_q];
  assign cur_cnt  = cnt_a[cur_ch_q];
  assign abort_c  = ~run_ok | ~cur_ctrl.en;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      me_q  <= 1'b0;
      nmi_q <= 1'b0;
      ae_q  <= 1'b0;
    end else begin
      if (glb_we_i) me_q <= glb_wdata_i[0];
      nmi_q <= nmi_i | (nmi_q & ~(glb_we_i & ~glb_wdata_i[1]));
      ae_q  <= misalign_c | (ae_q & ~(glb_we_i & ~glb_wdata_i[2]));
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q   <= 1'b0;
      cur_ch_q <= '0;
    end else if (!busy_q) begin
      if (gnt_any && align_ok) begin
        busy_q   <= 1'b1;
        cur_ch_q <= gnt_idx;
      end
    end else if (abort_c || bus_ack_i) begin
      busy_q <= 1'b0;
    end
  end

  assign bus_req_o  = busy_q & ~abort_c;
  assign bus_src_o  = src_a[cur_ch_q];
  assign bus_dst_o  = dst_a[cur_ch_q];
  assign bus_size_o = eff_size(cur_ctrl.size);
  assign bus_ch_o   = cur_ch_q;

  always_comb begin
    case (cfg_sel_i)
      SEL_SRC: cfg_rdata_o = src_a[cfg_ch_i];
      SEL_DST: cfg_rdata_o = dst_a[cfg_ch_i];
      SEL_CNT: cfg_rdata_o = AW'(cnt_a[cfg_ch_i]);
      default: cfg_rdata_o = AW'(ctrl_a[cfg_ch_i]);
    endcase
  end

  assign glb_rdata_o = {ae_q, nmi_q, me_q};

  assert_count_step_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o && bus_ack_i) |=> (cur_cnt == $past(cur_cnt) - 1'b1));

  assert_last_unit_done_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o && bus_ack_i && cur_cnt == CW'(1)) |=> cur_ctrl.done);

  assert_bus_aligned_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o |-> (addr_ok(bus_src_o[1:0], bus_size_o) && addr_ok(bus_dst_o[1:0], bus_size_o)));

  assert_nmi_halts_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nmi_i |=> !bus_req_o);

  assert_low_channel_first_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_q && elig[0]) |=> ((busy_q && cur_ch_q == '0) || ae_q));

  assert_one_grant_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt) && (gnt_any == (elig != '0)));

endmodule

// File: tb/dma_seq_bench.sv
module dma_seq_bench;

  localparam int N_CH = 2;
  localparam int AW   = 32;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            cfg_we = 1'b0;
  logic [0:0]      cfg_ch = '0;
  logic [1:0]      cfg_sel = '0;
  logic [AW-1:0]   cfg_wdata = '0;
  logic [AW-1:0]   cfg_rdata;
  logic            glb_we = 1'b0;
  logic [2:0]      glb_wdata = '0;
  logic [2:0]      glb_rdata;
  logic            nmi = 1'b0;
  logic [N_CH-1:0] req = '0;
  logic            bus_req;
  logic [AW-1:0]   bus_src, bus_dst;
  logic [1:0]      bus_size;
  logic [0:0]      bus_ch;
  logic            bus_ack = 1'b0;
  logic [N_CH-1:0] irq;

  int total = 0;
  int bad   = 0;

  always #4 clk = ~clk;

  dma_seq u_dma_seq (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_we_i(cfg_we), .cfg_ch_i(cfg_ch), .cfg_sel_i(cfg_sel),
    .cfg_wdata_i(cfg_wdata), .cfg_rdata_o(cfg_rdata),
    .glb_we_i(glb_we), .glb_wdata_i(glb_wdata), .glb_rdata_o(glb_rdata),
    .nmi_i(nmi), .req_i(req),
    .bus_req_o(bus_req), .bus_src_o(bus_src), .bus_dst_o(bus_dst),
    .bus_size_o(bus_size), .bus_ch_o(bus_ch), .bus_ack_i(bus_ack),
    .irq_o(irq)
  );

  // vectors on channel 0, one unit each
  localparam int V_N = 4;
  localparam logic [1:0]  V_SZ  [V_N] = '{2'd0, 2'd1, 2'd2, 2'd3};
  localparam logic [31:0] V_SRC [V_N] = '{32'h100, 32'h102, 32'h40, 32'h10};
  localparam logic [31:0] V_DST [V_N] = '{32'h200, 32'h300, 32'h80, 32'h20};
  localparam logic        V_SI  [V_N] = '{1'b1, 1'b1, 1'b0, 1'b1};
  localparam logic        V_DI  [V_N] = '{1'b1, 1'b0, 1'b1, 1'b1};
  localparam logic        V_IE  [V_N] = '{1'b1, 1'b0, 1'b1, 1'b0};
  localparam logic [1:0]  V_ESZ [V_N] = '{2'd0, 2'd1, 2'd2, 2'd2};
  localparam logic [31:0] V_SRX [V_N] = '{32'h101, 32'h104, 32'h40, 32'h14};
  localparam logic [31:0] V_DSX [V_N] = '{32'h201, 32'h300, 32'h84, 32'h24};

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr_cfg(input int ch, input int sel, input logic [31:0] d);
    cfg_ch = ch[0:0]; cfg_sel = sel[1:0]; cfg_wdata = d; cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic wr_glb(input logic [2:0] d);
    glb_wdata = d; glb_we = 1'b1;
    @(negedge clk);
    glb_we = 1'b0;
  endtask

  task automatic rd(input int ch, input int sel, output logic [31:0] v);
    cfg_ch = ch[0:0]; cfg_sel = sel[1:0];
    #1 v = cfg_rdata;
  endtask

  task automatic wait_bus(input int n, output bit ok);
    ok = 1'b0;
    for (int i = 0; i < n; i++) begin
      if (bus_req) begin ok = 1'b1; break; end
      @(negedge clk);
    end
  endtask

  task automatic no_bus(input int n, output bit ok);
    ok = 1'b1;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (bus_req) ok = 1'b0;
    end
  endtask

  task automatic ack_unit;
    bus_ack = 1'b1;
    @(negedge clk);
    bus_ack = 1'b0;
  endtask

  initial begin
    #(8 * 150000);
    bad++;
    total++;
    $display("FAIL R10 watchdog actual=%0d expected=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    bit ok;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R10 reset state
    chk(bus_req == 1'b0, "R10 bus_req", bus_req, 0);
    chk(glb_rdata == 3'b000, "R10 global", glb_rdata, 0);
    chk(irq == 2'b00, "R10 irq", irq, 0);
    rd(0, 3, v); chk(v == 0, "R10 ctrl", v, 0);
    rd(1, 2, v); chk(v == 0, "R10 count", v, 0);

    // R1 master enable off blocks an otherwise ready channel
    wr_cfg(0, 0, 32'h0); wr_cfg(0, 1, 32'h10); wr_cfg(0, 2, 3);
    wr_cfg(0, 3, 32'hE9);
    no_bus(6, ok); chk(ok, "R1 idle without master enable", !ok, 0);
    wr_glb(3'b001);
    wait_bus(8, ok); chk(ok, "R1 starts with all enables", ok, 1);
    chk(bus_src == 0 && bus_dst == 32'h10, "R4 first addresses", bus_src, 0);
    chk(bus_size == 2'd2 && bus_ch == 0, "R4 word size", bus_size, 2);
    ack_unit();
    rd(0, 2, v); chk(v == 2, "R5 count after one unit", v, 2);

    // R3 auto request continues; R2 suspend by master enable
    wait_bus(8, ok); chk(ok && bus_src == 32'h4, "R3 auto next unit", bus_src, 32'h4);
    wr_glb(3'b000);
    chk(bus_req == 1'b0, "R2 master clear drops request", bus_req, 0);
    rd(0, 2, v); chk(v == 2, "R2 count held on suspend", v, 2);
    no_bus(4, ok); chk(ok, "R2 stays suspended", !ok, 0);
    wr_glb(3'b001);
    wait_bus(8, ok); chk(ok && bus_src == 32'h4, "R2 resume same unit", bus_src, 32'h4);
    ack_unit();
    wait_bus(8, ok);
    wr_cfg(0, 3, 32'h0);
    chk(bus_req == 1'b0, "R2 channel clear aborts", bus_req, 0);
    rd(0, 2, v); chk(v == 1, "R2 count held on abort", v, 1);

    // R8 NMI
    wr_cfg(0, 3, 32'hE9);
    wait_bus(8, ok); chk(ok && bus_src == 32'h8, "R8 pre-nmi unit", bus_src, 32'h8);
    nmi = 1'b1; @(negedge clk); nmi = 1'b0;
    chk(bus_req == 1'b0, "R8 nmi drops request", bus_req, 0);
    chk(glb_rdata == 3'b011, "R8 nmi flag", glb_rdata, 3'b011);
    no_bus(5, ok); chk(ok, "R8 halted", !ok, 0);
    wr_glb(3'b011);
    chk(glb_rdata[1] == 1'b1, "R11 nmi flag kept on write 1", glb_rdata, 3'b011);
    wr_glb(3'b001);
    wait_bus(8, ok); chk(ok, "R8 resumes after clear", ok, 1);
    ack_unit();
    rd(0, 2, v); chk(v == 0, "R5 count reaches zero", v, 0);
    rd(0, 3, v); chk(v[1] == 1'b1, "R6 end flag set", v[1], 1);
    chk(irq[0] == 1'b0, "R6 irq masked", irq[0], 0);

    // R11 end flag blocks restart
    wr_cfg(0, 2, 2);
    no_bus(5, ok); chk(ok, "R11 reload with end flag idle", !ok, 0);
    wr_cfg(0, 3, 32'hEB);
    rd(0, 3, v); chk(v[1] == 1'b1, "R11 end flag kept on write 1", v[1], 1);
    no_bus(3, ok); chk(ok, "R11 still idle", !ok, 0);
    wr_cfg(0, 3, 32'hE9);
    wait_bus(8, ok); chk(ok, "R11 restart after clear", ok, 1);
    ack_unit();
    wr_cfg(0, 3, 32'h0);
    no_bus(3, ok);
    rd(0, 2, v); chk(v == 1, "R5 count after restart unit", v, 1);

    // R3 request mode, R9 priority
    wr_cfg(1, 0, 32'h500); wr_cfg(1, 1, 32'h600); wr_cfg(1, 2, 1); wr_cfg(1, 3, 32'h45);
    wr_cfg(0, 0, 32'h700); wr_cfg(0, 1, 32'h800); wr_cfg(0, 2, 1); wr_cfg(0, 3, 32'h01);
    no_bus(5, ok); chk(ok, "R3 no request no unit", !ok, 0);
    req = 2'b11;
    wait_bus(8, ok); chk(ok && bus_ch == 0, "R9 channel 0 first", bus_ch, 0);
    chk(bus_src == 32'h700 && bus_size == 0, "R4 byte unit ch0", bus_src, 32'h700);
    ack_unit();
    wait_bus(8, ok); chk(ok && bus_ch == 1, "R9 channel 1 next", bus_ch, 1);
    chk(bus_src == 32'h500, "R3 request unit ch1", bus_src, 32'h500);
    ack_unit();
    req = 2'b00;
    chk(irq == 2'b10, "R6 irq follows enable", irq, 2'b10);
    rd(1, 0, v); chk(v == 32'h501, "R4 byte increment", v, 32'h501);
    rd(0, 0, v); chk(v == 32'h700, "R4 fixed source", v, 32'h700);
    wr_cfg(0, 3, 0); wr_cfg(1, 3, 0);
    chk(irq == 2'b00, "R11 end flags cleared", irq, 0);

    // vector table
    for (int k = 0; k < V_N; k++) begin
      logic [31:0] c;
      c = 32'h9 | ({31'd0, V_IE[k]} << 2) | ({30'd0, V_SZ[k]} << 4)
        | ({31'd0, V_SI[k]} << 6) | ({31'd0, V_DI[k]} << 7);
      wr_cfg(0, 0, V_SRC[k]); wr_cfg(0, 1, V_DST[k]); wr_cfg(0, 2, 1);
      wr_cfg(0, 3, c);
      wait_bus(8, ok);
      chk(ok && bus_src == V_SRC[k] && bus_dst == V_DST[k], "R4 vector addresses", bus_src, V_SRC[k]);
      chk(bus_size == V_ESZ[k], "R4 vector size", bus_size, V_ESZ[k]);
      ack_unit();
      rd(0, 0, v); chk(v == V_SRX[k], "R4 vector source step", v, V_SRX[k]);
      rd(0, 1, v); chk(v == V_DSX[k], "R4 vector destination step", v, V_DSX[k]);
      chk(irq[0] == V_IE[k], "R6 vector irq", irq[0], V_IE[k]);
      no_bus(2, ok); chk(ok, "R6 no unit past zero", !ok, 0);
      wr_cfg(0, 3, 0);
    end

    // R7 misaligned halfword freezes all channels
    wr_cfg(1, 0, 32'h40); wr_cfg(1, 1, 32'h50); wr_cfg(1, 2, 1);
    wr_cfg(0, 0, 32'h901); wr_cfg(0, 1, 32'hA00); wr_cfg(0, 2, 2);
    wr_cfg(0, 3, 32'h19);
    wr_cfg(1, 3, 32'h29);
    no_bus(5, ok); chk(ok, "R7 no bus on misalign", !ok, 0);
    chk(glb_rdata == 3'b101, "R7 address error flag", glb_rdata, 3'b101);
    rd(0, 2, v); chk(v == 2, "R7 count untouched", v, 2);
    wr_cfg(0, 3, 0);
    wr_glb(3'b001);
    wait_bus(8, ok); chk(ok && bus_ch == 1, "R7 other channel after clear", bus_ch, 1);
    ack_unit();

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule